// File: doc/BRIEF.md
# Half-Duplex Serial Command Master

This block drives a four-wire half-duplex serial link as its master. Each frame opens by pulling chip select low and shifting out an 8- or 16-bit command while the peripheral stays silent. For a read, it then clocks a reply character of `RSP_W` bits back in and presents that word on a single-cycle valid pulse. A write frame closes as soon as its command is out. The serial clock rests low and toggles only while a frame is active. The block advances one serial half-period per `half_tick` strobe, so the bit rate is set by whoever generates that strobe.

Two timing variants are selectable. In format 1 the master changes data on the falling clock edge and samples on the rising edge, and one idle bit period separates the last command bit from the first reply bit. In format 2 the master both changes and samples on the falling edge. The peripheral answers on the rising edge, so the reply begins half a bit after the command. In format 1, a chaining option keeps chip select low and starts the next command on the same edge that ends the previous frame. After a frame that is not chained, chip select rises half a serial period after the last falling edge, plus two half-periods for each unit of `cfg_tail`.

The controller has five states. `S_IDLE` has chip select high and goes to `S_CMD` when a request is accepted. `S_CMD` shifts the command out. It moves to `S_GAP` for a format-1 read, to `S_RSP` for a format-2 read, to `S_CMD` again when chaining a write, and to `S_TAIL` otherwise. `S_GAP` runs the single idle bit of format 1 and then moves to `S_RSP`. `S_RSP` shifts the reply in and ends in `S_CMD` (chained) or `S_TAIL`. `S_TAIL` counts the release delay and returns to `S_IDLE`.

Top module: `hdx_cmd_master`

## Requirements
- R1: With no request pending, `mw_cs_n` is 1, `mw_sclk` is 0 and `rsp_valid` is 0. Whenever `mw_cs_n` is 1, `mw_sclk` is 0.
- R2: When a request is accepted, `mw_cs_n` falls and `mw_mosi` presents the first command bit in the same cycle. `mw_sclk` first rises at the next `half_tick`, which is the middle of that bit. After that it changes level only on clocks that follow a `half_tick`.
- R3: When `req_two_byte` is 0, the command is `req_cmd[7:0]` (8 bits). When it is 1, the command is all 16 bits of `req_cmd`. `mw_mosi` changes only while `mw_sclk` is low, so each command bit is stable at its rising edge.
- R4: When `cfg_lsb_first` is 0, the highest command bit goes out first and the first reply bit received lands in `rsp_data[RSP_W-1]`. When it is 1, bit 0 goes out first and the first reply bit lands in `rsp_data[0]`.
- R5: A format-1 read (`cfg_fmt2`=0) has one idle clock period after the command and then `RSP_W` reply periods. `mw_miso` is sampled at rising edges. The frame has N+1+`RSP_W` rising edges, where N is the command length.
- R6: A format-2 read (`cfg_fmt2`=1) begins the reply straight after the command and samples `mw_miso` at falling edges. The frame has N+`RSP_W` rising edges.
- R7: A write (`req_read`=0) ends after its N command clocks and produces no `rsp_valid`.
- R8: Each read yields exactly one `rsp_valid` pulse, one clock wide, and `rsp_data` at that pulse carries the reply word.
- R9: After a frame that is not chained, `mw_cs_n` rises 1+2·`cfg_tail` half-ticks after the last falling edge of `mw_sclk`.
- R10: In format 1 with `cfg_b2b`=1 and a request waiting at the last falling edge, `mw_cs_n` stays low and the next command's first bit is driven on that edge. In format 2, `cfg_b2b` has no effect.
- R11: `req_ready` is asserted only in a `half_tick` cycle: either in `S_IDLE`, or at the end of a frame where chaining is allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | One-cycle strobe marking each serial half-period |
| cfg_fmt2 | input | 1 | 0: format 1, 1: format 2 (latched per frame) |
| cfg_lsb_first | input | 1 | Bit order for command and reply (latched per frame) |
| cfg_b2b | input | 1 | Allow chaining frames in format 1 |
| cfg_tail | input | TAIL_W | Extra chip-select hold, in serial periods |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_read | input | 1 | 1: read frame, 0: write frame |
| req_two_byte | input | 1 | 1: 16-bit command, 0: 8-bit command |
| req_cmd | input | 2*BYTE_W | Command bits |
| rsp_valid | output | 1 | One-cycle strobe: reply word ready |
| rsp_data | output | RSP_W | Reply word |
| mw_cs_n | output | 1 | Chip select, active low |
| mw_sclk | output | 1 | Serial clock, idles low |
| mw_mosi | output | 1 | Master-to-peripheral data |
| mw_miso | input | 1 | Peripheral-to-master data |

## Verification
The case hardest to reach from the ports is a chained frame. A second request has to be waiting on exactly the falling edge that ends the previous frame, so that the next command bit appears with chip select still low. The bench issues requests one after another without waiting for frames to finish. The next request therefore sits on `req_valid` for the whole current frame and meets that edge. The same stimulus, repeated in format 2, shows that chaining is refused there. Around this, a sweep over both formats, both bit orders, both command lengths, read and write, and all four tail settings checks each frame against a peripheral model in the bench that answers on the edges of the selected format.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_GAP,
        S_RSP,
        S_TAIL
    } hdx_state_e;

endpackage

// File: rtl/hdx_tail_timer.sv
module hdx_tail_timer #(
    parameter int TAIL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [TAIL_W-1:0] extra,
    output logic              expire
);
    localparam int CW = TAIL_W + 1;

    logic [CW-1:0] cnt;

    // Counts two half-periods per unit of extra hold; expiry on the tick after zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= {extra, 1'b0};
        else if (tick && cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expire = tick && !load && (cnt == '0);

endmodule

// File: rtl/hdx_rsp_capture.sv
module hdx_rsp_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    input  logic         finish,
    input  logic         incl_din,
    input  logic         lsb_first,
    output logic [W-1:0] data,
    output logic         valid
);
    logic [W-1:0] sh;
    logic [W-1:0] word;
    logic [W-1:0] word_rev;

    // Final sample arrives in the same cycle as finish when incl_din is set
    always_comb begin
        word = incl_din ? {sh[W-2:0], din} : sh;
        for (int i = 0; i < W; i++)
            word_rev[i] = word[W-1-i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            if (shift_en)
                sh <= {sh[W-2:0], din};
            valid <= finish;
            if (finish)
                data <= lsb_first ? word_rev : word;
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R8

endmodule

// File: rtl/hdx_cmd_master.sv
module hdx_cmd_master
    import hdx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int RSP_W  = 8,
    parameter int TAIL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                half_tick,
    input  logic                cfg_fmt2,
    input  logic                cfg_lsb_first,
    input  logic                cfg_b2b,
    input  logic [TAIL_W-1:0]   cfg_tail,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_read,
    input  logic                req_two_byte,
    input  logic [2*BYTE_W-1:0] req_cmd,
    output logic                rsp_valid,
    output logic [RSP_W-1:0]    rsp_data,
    output logic                mw_cs_n,
    output logic                mw_sclk,
    output logic                mw_mosi,
    input  logic                mw_miso
);
    localparam int CMD_W  = 2 * BYTE_W;
    localparam int MAXB   = (CMD_W > RSP_W) ? CMD_W : RSP_W;
    localparam int CNT_W  = $clog2(MAXB);
    localparam int CIDX_W = $clog2(CMD_W);

    hdx_state_e state, state_nx;

    logic [CMD_W-1:0]  cmd_q;
    logic              two_q, lsb_q, fmt2_q, rd_q;
    logic [TAIL_W-1:0] tail_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sclk_q, cs_n_q, mosi_q;

    logic active, tick_rise, tick_fall;
    logic last_cmd, last_rsp, cmd_done, rsp_done, frame_end;
    logic chain_ok, accept, tail_expire;

    function automatic logic pick_bit(input logic [CMD_W-1:0] c, input logic two,
                                      input logic lsb, input logic [CNT_W-1:0] k);
        logic [CNT_W-1:0] top_i;
        logic [CNT_W-1:0] pos;
        top_i = two ? CNT_W'(CMD_W - 1) : CNT_W'(BYTE_W - 1);
        pos   = lsb ? k : (top_i - k);
        return c[CIDX_W'(pos)];
    endfunction

    always_comb begin
        active    = (state == S_CMD) || (state == S_GAP) || (state == S_RSP);
        tick_rise = half_tick && active && !sclk_q;
        tick_fall = half_tick && active && sclk_q;
        last_cmd  = bit_cnt == (two_q ? CNT_W'(CMD_W - 1) : CNT_W'(BYTE_W - 1));
        last_rsp  = bit_cnt == CNT_W'(RSP_W - 1);
        cmd_done  = (state == S_CMD) && tick_fall && last_cmd;
        rsp_done  = (state == S_RSP) && tick_fall && last_rsp;
        frame_end = (cmd_done && !rd_q) || rsp_done;
        chain_ok  = frame_end && !fmt2_q && cfg_b2b;
        req_ready = ((state == S_IDLE) && half_tick) || chain_ok;
        accept    = req_valid && req_ready;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_CMD;
            S_CMD:
                if (cmd_done) begin
                    if (rd_q)        state_nx = fmt2_q ? S_RSP : S_GAP;
                    else if (accept) state_nx = S_CMD;
                    else             state_nx = S_TAIL;
                end
            S_GAP:  if (tick_fall) state_nx = S_RSP;
            S_RSP:  if (rsp_done) state_nx = accept ? S_CMD : S_TAIL;
            S_TAIL: if (tail_expire) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            two_q   <= 1'b0;
            lsb_q   <= 1'b0;
            fmt2_q  <= 1'b0;
            rd_q    <= 1'b0;
            tail_q  <= '0;
            bit_cnt <= '0;
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            mosi_q  <= 1'b0;
        end else begin
            if (active && half_tick)
                sclk_q <= !sclk_q;
            if ((state == S_CMD) && tick_fall) begin
                if (last_cmd) begin
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    mosi_q  <= pick_bit(cmd_q, two_q, lsb_q, bit_cnt + CNT_W'(1));
                end
            end
            if ((state == S_RSP) && tick_fall)
                bit_cnt <= last_rsp ? '0 : bit_cnt + CNT_W'(1);
            if ((state == S_TAIL) && tail_expire)
                cs_n_q <= 1'b1;
            if (accept) begin
                cmd_q   <= req_cmd;
                two_q   <= req_two_byte;
                lsb_q   <= cfg_lsb_first;
                fmt2_q  <= cfg_fmt2;
                rd_q    <= req_read;
                tail_q  <= cfg_tail;
                bit_cnt <= '0;
                cs_n_q  <= 1'b0;
                mosi_q  <= pick_bit(req_cmd, req_two_byte, cfg_lsb_first, '0);
            end
        end
    end

    assign mw_cs_n = cs_n_q;
    assign mw_sclk = sclk_q;
    assign mw_mosi = mosi_q;

    hdx_tail_timer #(.TAIL_W(TAIL_W)) u_tail (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (half_tick),
        .load   (frame_end),
        .extra  (tail_q),
        .expire (tail_expire)
    );

    hdx_rsp_capture #(.W(RSP_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  ((state == S_RSP) && (fmt2_q ? tick_fall : tick_rise)),
        .din       (mw_miso),
        .finish    (rsp_done),
        .incl_din  (fmt2_q),
        .lsb_first (lsb_q),
        .data      (rsp_data),
        .valid     (rsp_valid)
    );

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        mw_cs_n |-> !mw_sclk); // R1
    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mw_sclk) |-> $past(half_tick)); // R2
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sclk |-> $stable(mw_mosi)); // R3
    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> half_tick); // R11
    AST_CHAIN_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && accept) |=> !mw_cs_n); // R10

endmodule

// File: tb/tb_hdx_cmd_master.sv
module tb_hdx_cmd_master;
    localparam int BYTE_W = 8;
    localparam int RSP_W  = 8;
    localparam int TAIL_W = 2;
    localparam int DIV    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_tick;
    logic cfg_fmt2 = 1'b0, cfg_lsb_first = 1'b0, cfg_b2b = 1'b0;
    logic [TAIL_W-1:0] cfg_tail = '0;
    logic req_valid = 1'b0, req_read = 1'b0, req_two_byte = 1'b0;
    logic [2*BYTE_W-1:0] req_cmd = '0;
    logic req_ready, rsp_valid;
    logic [RSP_W-1:0] rsp_data;
    logic mw_cs_n, mw_sclk, mw_mosi;
    logic mw_miso = 1'b0;

    always #10 clk = ~clk;

    hdx_cmd_master #(.BYTE_W(BYTE_W), .RSP_W(RSP_W), .TAIL_W(TAIL_W)) dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .cfg_fmt2(cfg_fmt2), .cfg_lsb_first(cfg_lsb_first), .cfg_b2b(cfg_b2b),
        .cfg_tail(cfg_tail), .req_valid(req_valid), .req_ready(req_ready),
        .req_read(req_read), .req_two_byte(req_two_byte), .req_cmd(req_cmd),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mw_cs_n(mw_cs_n),
        .mw_sclk(mw_sclk), .mw_mosi(mw_mosi), .mw_miso(mw_miso)
    );

    // Half-period strobe every DIV clocks
    logic [1:0] dcnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            dcnt      <= '0;
            half_tick <= 1'b0;
        end else begin
            dcnt      <= (dcnt == DIV - 1) ? 2'd0 : dcnt + 2'd1;
            half_tick <= (dcnt == DIV - 1);
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected frames
    logic        f_rd[0:127], f_two[0:127], f_lsb[0:127], f_fmt2[0:127], f_b2b[0:127];
    logic [1:0]  f_tail[0:127];
    logic [15:0] f_cmd[0:127];
    logic [7:0]  f_rep[0:127];
    logic [7:0]  rsp_exp[0:127];
    int nf = 0;
    int nr = 0;

    // Peripheral model and frame monitor
    int m_idx = 0, r_cnt = 0, f_cnt = 0, done_cnt = 0, cs_rise_cnt = 0, rsp_idx = 0;
    int cs_fall_cyc = 0, last_fall_cyc = 0;
    logic [15:0] rx = '0;
    bit from_b2b = 0, pcs = 1, psclk = 0, prev_rv = 0;

    task automatic finish_frame();
        int n;
        int exp_r;
        n = f_two[m_idx] ? 16 : 8;
        exp_r = f_rd[m_idx] ? (f_fmt2[m_idx] ? n + RSP_W : n + RSP_W + 1) : n;
        check(rx == (f_two[m_idx] ? f_cmd[m_idx] : {8'h00, f_cmd[m_idx][7:0]}),
              "R3/R4 command bits", rx, f_cmd[m_idx]);
        check(r_cnt == exp_r, f_rd[m_idx] ? (f_fmt2[m_idx] ? "R6 rising edges" : "R5 rising edges")
                                          : "R7 rising edges", r_cnt, exp_r);
        m_idx++;
        done_cnt++;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int n;
            int endf;
            n = f_two[m_idx] ? 16 : 8;
            endf = f_rd[m_idx] ? (f_fmt2[m_idx] ? n + RSP_W - 1 : n + RSP_W) : n - 1;
            if (pcs && !mw_cs_n) begin
                r_cnt = 0; f_cnt = 0; rx = '0; from_b2b = 0;
                cs_fall_cyc = cyc;
            end
            if (!psclk && mw_sclk) begin
                if (r_cnt == 0 && !from_b2b)
                    check(cyc - cs_fall_cyc == DIV, "R2 first rise delay", cyc - cs_fall_cyc, DIV);
                if (r_cnt < n)
                    rx[f_lsb[m_idx] ? r_cnt : n - 1 - r_cnt] = mw_mosi;
                if (f_rd[m_idx] && f_fmt2[m_idx] && r_cnt >= n && r_cnt - n < RSP_W)
                    mw_miso = f_rep[m_idx][f_lsb[m_idx] ? r_cnt - n : RSP_W - 1 - (r_cnt - n)];
                r_cnt++;
            end
            if (psclk && !mw_sclk) begin
                if (f_rd[m_idx] && !f_fmt2[m_idx]) begin
                    if (f_cnt == n - 1)
                        mw_miso = 1'b0;
                    else if (f_cnt >= n && f_cnt - n < RSP_W)
                        mw_miso = f_rep[m_idx][f_lsb[m_idx] ? f_cnt - n : RSP_W - 1 - (f_cnt - n)];
                end
                last_fall_cyc = cyc;
                if (f_cnt == endf && f_b2b[m_idx]) begin
                    finish_frame();
                    from_b2b = 1; r_cnt = 0; f_cnt = 0; rx = '0;
                end else begin
                    f_cnt++;
                end
            end
            if (!pcs && mw_cs_n) begin
                cs_rise_cnt++;
                check(cyc - last_fall_cyc == DIV * (1 + 2 * f_tail[m_idx]), "R9 release delay",
                      cyc - last_fall_cyc, DIV * (1 + 2 * f_tail[m_idx]));
                finish_frame();
            end
            if (rsp_valid) begin
                check(!prev_rv, "R8 pulse width", 2, 1);
                check(rsp_data == rsp_exp[rsp_idx], "R8/R4 reply word", rsp_data, rsp_exp[rsp_idx]);
                rsp_idx++;
            end
            prev_rv = rsp_valid;
            pcs = mw_cs_n;
            psclk = mw_sclk;
        end
    end

    task automatic issue(input bit rd, input bit two, input bit lsb, input bit fmt2,
                         input bit b2b, input logic [1:0] tail, input logic [15:0] cmd,
                         input logic [7:0] rep, input bit chained);
        f_rd[nf] = rd; f_two[nf] = two; f_lsb[nf] = lsb; f_fmt2[nf] = fmt2;
        f_b2b[nf] = chained; f_tail[nf] = tail; f_cmd[nf] = cmd; f_rep[nf] = rep;
        if (rd) begin
            rsp_exp[nr] = rep;
            nr++;
        end
        nf++;
        req_read = rd; req_two_byte = two; req_cmd = cmd;
        cfg_lsb_first = lsb; cfg_fmt2 = fmt2; cfg_b2b = b2b; cfg_tail = tail;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int rises0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mw_cs_n == 1'b1, "R1 reset cs", mw_cs_n, 1);
        check(mw_sclk == 1'b0, "R1 reset sclk", mw_sclk, 0);
        check(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
        repeat (20) @(negedge clk);
        check(mw_cs_n == 1'b1 && mw_sclk == 1'b0, "R1 idle pins", {mw_cs_n, mw_sclk}, 2);

        // Sweep: format x order x length x direction x tail
        for (int fm = 0; fm < 2; fm++)
            for (int lb = 0; lb < 2; lb++)
                for (int tw = 0; tw < 2; tw++)
                    for (int rd = 0; rd < 2; rd++)
                        for (int tl = 0; tl < 4; tl++) begin
                            logic [15:0] c;
                            logic [7:0] rp;
                            c  = 16'(nf * 16'h9E37 + 16'h1234);
                            rp = 8'(nf * 8'h5B) ^ 8'hC3;
                            issue(rd[0], tw[0], lb[0], fm[0], 1'b0, tl[1:0], c, rp, 1'b0);
                            while (done_cnt < nf) @(negedge clk);
                        end

        // R10: chained frames in format 1
        rises0 = cs_rise_cnt;
        issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 16'hA53C, 8'h96, 1'b1);
        issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h00E1, 8'h00, 1'b1);
        issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h007B, 8'h3D, 1'b0);
        while (done_cnt < nf) @(negedge clk);
        check(cs_rise_cnt - rises0 == 1, "R10 chained cs releases", cs_rise_cnt - rises0, 1);

        // R10: chaining request ignored in format 2
        rises0 = cs_rise_cnt;
        issue(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 16'h00C4, 8'h71, 1'b0);
        issue(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 16'h5EED, 8'hE8, 1'b0);
        while (done_cnt < nf) @(negedge clk);
        check(cs_rise_cnt - rises0 == 2, "R10 format 2 no chaining", cs_rise_cnt - rises0, 2);

        repeat (10) @(negedge clk);
        check(rsp_idx == nr, "R7/R8 reply count", rsp_idx, nr);
        check(mw_cs_n == 1'b1 && mw_sclk == 1'b0, "R1 final idle", {mw_cs_n, mw_sclk}, 2);
        summary();
        $finish;
    end

endmodule